// File: doc/BRIEF.md
# Paired-Channel PWM Timer

A four-channel timer that makes pulse-width-modulated waveforms from cascaded down-counters. A channel in master role is a reloading interval counter, and its reload value sets the PWM period. A channel in slave role is a one-shot down-counter. The master's terminal-count pulse retriggers it, and its own reload value sets the active width of its PWM output. All counting advances only on cycles where the count-clock enable is high.

Channel 0 is always a master and channel 1 is always a slave. A split-select input decides how channels 2 and 3 are paired. When it is low, channel 0 drives channels 1, 2 and 3. When it is high, channel 2 becomes a second master and drives channel 3. Each channel has a data register written through a shared data bus with a per-channel write strobe. Each channel also has a start bit and a stop bit, an interrupt pulse and a PWM output. A data value written at any time only reaches the counters at the next master terminal event. Software therefore rewrites both registers right after a master interrupt.

Top module: `pwm_pair_timer`

## Requirements
- R1: One count-clock tick after a master's start bit is pulsed, the master raises its interrupt and loads its data value D into its counter.
- R2: A running master interrupts every D+1 ticks. It reloads D each time and keeps doing so until stopped. Cycles with the count enable low do not advance any counter.
- R3: On each trigger from its master, a running slave loads its data value S. Its interrupt comes S+1 ticks after the master interrupt, provided S is no greater than D.
- R4: A slave output goes active (1) on the tick after the master interrupt and inactive (0) on the tick where the slave counter is at zero. The active width is S ticks, so S=0 never drives it active.
- R5: When S is greater than or equal to D+1, the slave output stays active for the whole period.
- R6: A data write made between master events changes neither the current period nor the current width. It takes effect from the next master interrupt.
- R7: With split low, channel 0 triggers channels 1, 2 and 3. With split high, channel 0 triggers channel 1 and channel 2 triggers channel 3. Master PWM outputs stay at 0.
- R8: A stop pulse halts the channel. From the next cycle its interrupt stays low and its output reads 0. If stop and start arrive in the same cycle, stop wins.
- R9: A slave that has not been started, or whose master is not running, ignores triggers: its output stays 0 and it raises no interrupt.
- R10: Interrupts are single-cycle pulses that occur only in cycles where the count enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-clock enable (one tick per high cycle) |
| pair_split_i | input | 1 | 1: channel 2 is master of channel 3 |
| wr_i | input | 4 | Per-channel data register write strobe |
| wdata_i | input | CNT_W | Data register write value |
| start_i | input | 4 | Per-channel start command pulse |
| stop_i | input | 4 | Per-channel stop command pulse |
| irq_o | output | 4 | Per-channel interrupt pulse |
| pwm_o | output | 4 | Per-channel PWM output (active high, slaves only) |

## Verification
The bench builds the block with the default 16-bit counters. It uses small data values so that every period and active width can be counted cycle by cycle within a short run. These values reach the 0% width, exact-period width, over-range clamp and width-equals-period cases. They also reach a mid-period rewrite of both registers. Both pairing layouts are covered, and a halved count enable checks that only ticks advance the counters.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_CH = 4;
  typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/pwm_trig_route.sv
module pwm_trig_route
  import pwm_pkg::*;
(
  input  logic     split_i,
  input  logic     irq_m0_i,
  input  logic     irq_m2_i,
  output ch_mask_t master_mode_o,
  output ch_mask_t trig_o
);
  always_comb begin
    master_mode_o = {1'b0, split_i, 1'b0, 1'b1};
    trig_o[0]     = 1'b0;
    trig_o[1]     = irq_m0_i;
    trig_o[2]     = split_i ? 1'b0 : irq_m0_i;
    trig_o[3]     = split_i ? irq_m2_i : irq_m0_i;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             master_mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             trig_i,
  output logic             irq_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] data_q, cnt_q;
  logic run_q, pend_q, busy_q, first_q, pwm_q;
  logic is_zero;

  assign is_zero = (cnt_q == '0);
  assign pwm_o   = pwm_q;

  always_comb begin
    if (master_mode_i) irq_o = tick_i & run_q & (pend_q | is_zero);
    else               irq_o = tick_i & run_q & busy_q & is_zero;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      if (wr_i) data_q <= wdata_i;
      if (stop_i) begin
        run_q   <= 1'b0;
        pend_q  <= 1'b0;
        busy_q  <= 1'b0;
        first_q <= 1'b0;
        pwm_q   <= 1'b0;
      end else if (start_i) begin
        run_q   <= 1'b1;
        pend_q  <= master_mode_i;
        busy_q  <= 1'b0;
        first_q <= 1'b0;
        pwm_q   <= 1'b0;
      end else if (tick_i && run_q) begin
        if (master_mode_i) begin
          // interval mode: reload on start or terminal count
          if (pend_q || is_zero) begin
            cnt_q  <= data_q;
            pend_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          // one-count mode
          if (busy_q) begin
            if (is_zero) begin
              busy_q <= 1'b0;
              pwm_q  <= 1'b0;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              if (first_q) pwm_q <= 1'b1;
            end
            first_q <= 1'b0;
          end
          // retrigger overrides the running count (clamps duty at 100%)
          if (trig_i) begin
            cnt_q   <= data_q;
            busy_q  <= 1'b1;
            first_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             pair_split_i,
  input  logic [3:0]       wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [3:0]       start_i,
  input  logic [3:0]       stop_i,
  output logic [3:0]       irq_o,
  output logic [3:0]       pwm_o
);
  ch_mask_t master_mode, trig;

  pwm_trig_route u_route (
    .split_i      (pair_split_i),
    .irq_m0_i     (irq_o[0]),
    .irq_m2_i     (irq_o[2]),
    .master_mode_o(master_mode),
    .trig_o       (trig)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tick_i       (cnt_en_i),
      .master_mode_i(master_mode[k]),
      .start_i      (start_i[k]),
      .stop_i       (stop_i[k]),
      .wr_i         (wr_i[k]),
      .wdata_i      (wdata_i),
      .trig_i       (trig[k]),
      .irq_o        (irq_o[k]),
      .pwm_o        (pwm_o[k])
    );
  end
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cnt_en_i,
  input logic [3:0] start_i,
  input logic [3:0] stop_i,
  input logic [3:0] irq_o,
  input logic [3:0] pwm_o
);
  assert_master0_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_o[0]);

  assert_master_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i[0] |=> !irq_o[0]);

  for (genvar k = 1; k < 4; k++) begin : g_sl
    assert_stop_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i[k] |=> (!pwm_o[k] && !irq_o[k]));

    assert_rise_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_o[k]) |-> $past(cnt_en_i));

    assert_fall_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwm_o[k]) |-> $past(irq_o[k] | stop_i[k] | start_i[k]));
  end
endmodule

bind pwm_pair_timer pwm_pair_timer_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_en_i(cnt_en_i),
  .start_i (start_i),
  .stop_i  (stop_i),
  .irq_o   (irq_o),
  .pwm_o   (pwm_o)
);

// File: tb/sim_pwm_pair_timer.sv
`timescale 1ns/1ps
module sim_pwm_pair_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic        split = 1'b0;
  logic [3:0]  wr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  start = '0;
  logic [3:0]  stop = '0;
  logic [3:0]  irq, pwm;
  logic        half_rate = 1'b0;
  int checks = 0, failures = 0;
  int per;
  int hi [4];
  int bad_irq;

  always #4 clk = ~clk;

  always @(negedge clk) cnt_en <= half_rate ? ~cnt_en : 1'b1;

  pwm_pair_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .pair_split_i(split),
    .wr_i(wr), .wdata_i(wdata), .start_i(start), .stop_i(stop),
    .irq_o(irq), .pwm_o(pwm)
  );

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ch(input int ch, input int val);
    @(negedge clk);
    wr = 4'b1 << ch;
    wdata = val[15:0];
    @(negedge clk);
    wr = '0;
  endtask

  task automatic cmd(input logic [3:0] st, input logic [3:0] sp);
    @(negedge clk);
    start = st;
    stop = sp;
    @(negedge clk);
    start = '0;
    stop = '0;
  endtask

  task automatic wait_irq(input int ch);
    do @(negedge clk); while (!irq[ch]);
  endtask

  // From one irq of master m to the next; counts cycles and active samples
  task automatic measure(input int m);
    wait_irq(m);
    per = 0;
    bad_irq = 0;
    for (int k = 0; k < 4; k++) hi[k] = 0;
    do begin
      @(negedge clk);
      per++;
      for (int k = 0; k < 4; k++) if (pwm[k]) hi[k]++;
      for (int k = 0; k < 4; k++) if (irq[k] && !cnt_en) bad_irq++;
    end while (!irq[m] && per < 5000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset irq", int'(irq), 0);
    chk("R4 reset pwm", int'(pwm), 0);
  endtask

  task automatic t_start();
    write_ch(0, 9);
    write_ch(1, 3);
    @(negedge clk);
    start = 4'b0011;
    @(negedge clk);
    start = '0;
    chk("R1 irq on first tick after start", int'(irq[0]), 1);
    @(negedge clk);
    chk("R10 irq single pulse", int'(irq[0]), 0);
    cmd('0, 4'hF);
  endtask

  task automatic t_duty(input int d, input int s, input int exp_hi, input string req);
    write_ch(0, d);
    write_ch(1, s);
    cmd(4'b0011, '0);
    wait_irq(0);
    measure(0);
    chk("R2 period", per, d + 1);
    chk(req, hi[1], exp_hi);
    cmd('0, 4'hF);
  endtask

  task automatic t_slave_irq();
    int n;
    write_ch(0, 9);
    write_ch(1, 3);
    cmd(4'b0011, '0);
    wait_irq(0);
    wait_irq(0);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq[1] && n < 100);
    chk("R3 slave irq delay", n, 4);
    cmd('0, 4'hF);
  endtask

  task automatic t_midwrite();
    write_ch(0, 9);
    write_ch(1, 3);
    cmd(4'b0011, '0);
    wait_irq(0);
    wait_irq(0);
    repeat (2) @(negedge clk);
    wdata = 16'd5; wr = 4'b0001;
    @(negedge clk);
    wdata = 16'd4; wr = 4'b0010;
    @(negedge clk);
    wr = '0;
    do begin
      @(negedge clk);
    end while (!irq[0]);
    // this master event loaded the new values; measure from here
    per = 0;
    for (int k = 0; k < 4; k++) hi[k] = 0;
    do begin
      @(negedge clk);
      per++;
      for (int k = 0; k < 4; k++) if (pwm[k]) hi[k]++;
    end while (!irq[0] && per < 5000);
    chk("R6 new period after event", per, 6);
    measure(0);
    chk("R6 new width after event", hi[1], 4);
    cmd('0, 4'hF);
  endtask

  task automatic t_midwrite_hold();
    write_ch(0, 9);
    write_ch(1, 3);
    cmd(4'b0011, '0);
    wait_irq(0);
    wait_irq(0);
    per = 0;
    for (int k = 0; k < 4; k++) hi[k] = 0;
    do begin
      @(negedge clk);
      per++;
      if (per == 3) begin wdata = 16'd5; wr = 4'b0011; end
      else wr = '0;
      for (int k = 0; k < 4; k++) if (pwm[k]) hi[k]++;
    end while (!irq[0] && per < 5000);
    chk("R6 current period unchanged", per, 10);
    chk("R6 current width unchanged", hi[1], 3);
    cmd('0, 4'hF);
  endtask

  task automatic t_pairs();
    split = 1'b0;
    write_ch(0, 9);
    write_ch(1, 2);
    write_ch(2, 5);
    write_ch(3, 8);
    cmd(4'b1111, '0);
    wait_irq(0);
    measure(0);
    chk("R7 ch1 width split=0", hi[1], 2);
    chk("R7 ch2 width split=0", hi[2], 5);
    chk("R7 ch3 width split=0", hi[3], 8);
    cmd('0, 4'hF);
    split = 1'b1;
    write_ch(0, 9);
    write_ch(1, 6);
    write_ch(2, 4);
    write_ch(3, 3);
    cmd(4'b1111, '0);
    wait_irq(2);
    measure(2);
    chk("R7 ch2 master period", per, 5);
    chk("R7 ch3 width from ch2", hi[3], 3);
    chk("R7 ch2 master pwm idle", hi[2], 0);
    measure(0);
    chk("R7 ch1 width from ch0", hi[1], 6);
    cmd('0, 4'hF);
    split = 1'b0;
  endtask

  task automatic t_ignore();
    int n;
    write_ch(0, 4);
    write_ch(1, 3);
    cmd(4'b0001, '0);
    n = 0;
    repeat (20) begin @(negedge clk); if (pwm[1] || irq[1]) n++; end
    chk("R9 unstarted slave ignores trigger", n, 0);
    cmd('0, 4'hF);
    cmd(4'b0010, '0);
    n = 0;
    repeat (20) begin @(negedge clk); if (pwm[1] || irq[1]) n++; end
    chk("R9 slave idle without master", n, 0);
    cmd('0, 4'hF);
  endtask

  task automatic t_stop();
    int n;
    write_ch(0, 9);
    write_ch(1, 8);
    cmd(4'b0011, '0);
    wait_irq(0);
    repeat (3) @(negedge clk);
    chk("R4 active before stop", int'(pwm[1]), 1);
    @(negedge clk);
    stop = 4'b0011;
    @(negedge clk);
    stop = '0;
    chk("R8 output cleared by stop", int'(pwm[1]), 0);
    n = 0;
    repeat (25) begin @(negedge clk); if (irq[0] || irq[1] || pwm[1]) n++; end
    chk("R8 halted after stop", n, 0);
    @(negedge clk);
    start = 4'b0011;
    stop = 4'b0011;
    @(negedge clk);
    start = '0;
    stop = '0;
    n = 0;
    repeat (25) begin @(negedge clk); if (irq[0] || pwm[1]) n++; end
    chk("R8 stop wins over start", n, 0);
  endtask

  task automatic t_half_rate();
    half_rate = 1'b1;
    write_ch(0, 4);
    write_ch(1, 2);
    cmd(4'b0011, '0);
    wait_irq(0);
    measure(0);
    chk("R2 period counts only ticks", per, 10);
    chk("R4 width counts only ticks", hi[1], 4);
    chk("R10 irq only with enable", bad_irq, 0);
    half_rate = 1'b0;
    cmd('0, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start();
    t_duty(9, 3, 3, "R4 width 3 of 10");
    t_duty(4, 0, 0, "R4 zero width");
    t_duty(7, 7, 7, "R4 width equals D");
    t_duty(4, 5, 5, "R5 S=D+1 full duty");
    t_duty(4, 20, 5, "R5 over-range clamp");
    t_slave_irq();
    t_midwrite_hold();
    t_midwrite();
    t_pairs();
    t_ignore();
    t_stop();
    t_half_rate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule